// File: doc/BRIEF.md
# Two-Requester Fixed-Priority Arbiter with Grant Hold

This block decides, every clock cycle, which of two requesters owns a shared resource. Both request inputs are sampled on the rising clock edge. The decision appears on registered grant outputs in the following cycle. The high-priority requester wins whenever it is requesting.

A fresh assertion of the high-priority request reserves the resource for a fixed window of cycles, set by a parameter with a default of two. During that window the grant stays with the high-priority side whatever the inputs do. When nobody is requesting, the grant is parked on the low-priority requester, so exactly one grant line is always high after reset. Typical use is in front of a shared port, where the parked grant lets the low-priority master start without a request-to-grant delay.

Top module: `prio_arb2`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `gnt_lo`=1 and `gnt_hi`=0. Reset clears the edge history, so `req_hi` high at the first sample after reset counts as a new rising request.
- R2: Grants are registered with one cycle of latency. If `req_hi` is 1 at a sampled edge, `gnt_hi`=1 in the next cycle, even when `req_lo` is also 1.
- R3: A low-to-high change of `req_hi` between consecutive samples sets `gnt_hi`=1 for each of the next HOLD_CYCLES cycles (default 2). This holds regardless of `req_hi` and `req_lo` during that window.
- R4: When both requests are 0 at a sample and no hold window is pending, `gnt_lo`=1 in the next cycle (parked grant).
- R5: When only `req_lo` is 1 at a sample and no hold window is pending, `gnt_lo`=1 in the next cycle.
- R6: In every cycle after the first reset edge, exactly one of `gnt_hi` and `gnt_lo` is 1.
- R7: A `req_hi` held high beyond the hold window keeps `gnt_hi`=1. The grant returns to `gnt_lo` one cycle after the first sample with `req_hi`=0 once the window has ended.
- R8: Single-cycle `req_hi` pulses separated by one low cycle each start a new window, giving an unbroken run of `gnt_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests sampled on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 1 | Request from the high-priority requester |
| req_lo | input | 1 | Request from the low-priority requester |
| gnt_hi | output | 1 | Registered grant to the high-priority requester |
| gnt_lo | output | 1 | Registered grant to the low-priority requester (parking target) |

## Verification
The bound checker checks these properties on every cycle:
- the one-hot grant pair;
- the reset grant value;
- priority for a high `req_hi`;
- the forced grant in both cycles after a rising `req_hi`;
- parking after an idle sample that follows a low `req_hi`.

Some behaviours only the bench scenarios can show, because they are sequences the properties do not tie together:
- the return of the grant after a long `req_hi`;
- the re-arming of the window by back-to-back pulses;
- a rising edge detected at the first sample after reset;
- `req_lo` being ignored during a window.

The bench drives these scenarios directly and compares every cycle against an independent model.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'b00,
    GNT_LO   = 2'b01,
    GNT_HI   = 2'b10
  } grant_e;
endpackage

// File: rtl/arb2_edge.sv
module arb2_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= req_in;
  end

  assign rise_o = req_in & ~prev_q;
endmodule

// File: rtl/arb2_hold.sv
module arb2_hold #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  output logic active_o
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

  generate
    if (HOLD_CYCLES <= 1) begin : g_no_hold
      assign active_o = 1'b0;
    end else begin : g_cnt
      logic [CNT_W-1:0] left_q;
      always_ff @(posedge clk) begin
        if (rst)                  left_q <= '0;
        else if (rise_i)          left_q <= RELOAD;
        else if (left_q != '0)    left_q <= left_q - 1'b1;
      end
      assign active_o = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/arb2_grant.sv
module arb2_grant
  import arb2_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   force_i,
  input  logic   req_hi,
  input  logic   req_lo,
  output grant_e grant_o
);
  grant_e next_g;

  always_comb begin
    casez ({force_i | req_hi, req_lo})
      2'b1?:   next_g = GNT_HI;
      2'b01:   next_g = GNT_LO;
      default: next_g = GNT_LO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) grant_o <= GNT_LO;
    else     grant_o <= next_g;
  end
endmodule

// File: rtl/prio_arb2.sv
module prio_arb2
  import arb2_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_hi,
  input  logic req_lo,
  output logic gnt_hi,
  output logic gnt_lo
);
  logic   rise;
  logic   hold_on;
  grant_e grant;

  arb2_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_hi),
    .rise_o (rise)
  );

  arb2_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (rise),
    .active_o (hold_on)
  );

  arb2_grant u_grant (
    .clk     (clk),
    .rst     (rst),
    .force_i (rise | hold_on),
    .req_hi  (req_hi),
    .req_lo  (req_lo),
    .grant_o (grant)
  );

  assign gnt_hi = grant[1];
  assign gnt_lo = grant[0];
endmodule

// File: rtl/arb2_chk.sv
module arb2_chk (
  input logic clk,
  input logic rst,
  input logic req_hi,
  input logic req_lo,
  input logic gnt_hi,
  input logic gnt_lo
);
  // R1: reset forces the parked grant
  p_reset_park_r1: assert property (@(posedge clk)
    rst |=> (gnt_lo && !gnt_hi));

  // R2: a high-priority request wins next cycle
  p_prio_r2: assert property (@(posedge clk) disable iff (rst)
    req_hi |=> gnt_hi);

  // R3: a rising request holds the grant for two cycles
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_hi) |=> gnt_hi ##1 gnt_hi);

  // R4: idle after a low req_hi parks on the low side
  p_park_r4: assert property (@(posedge clk) disable iff (rst)
    (!req_hi && !req_lo && !$past(req_hi)) |=> gnt_lo);

  // R5: low request alone is served when no window is pending
  p_lo_serve_r5: assert property (@(posedge clk) disable iff (rst)
    (!req_hi && req_lo && !$past(req_hi)) |=> gnt_lo);

  // R6: exactly one grant
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({gnt_hi, gnt_lo}) == 1);
endmodule

bind prio_arb2 arb2_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_hi (req_hi),
  .req_lo (req_lo),
  .gnt_hi (gnt_hi),
  .gnt_lo (gnt_lo)
);

// File: tb/sim_prio_arb2.sv
`timescale 1ns/1ps
module sim_prio_arb2;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_hi = 1'b0;
  logic req_lo = 1'b0;
  logic gnt_hi, gnt_lo;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  hi;
    logic  lo;
    string tag;
  } exp_t;
  exp_t sb[$];

  // model state
  logic m_prev = 1'b0;
  int   m_left = 0;

  always #2 clk = ~clk;

  prio_arb2 #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
    .gnt_hi(gnt_hi), .gnt_lo(gnt_lo)
  );

  task automatic drive(input logic r, input logic h, input logic l, input string ovr);
    exp_t e;
    @(negedge clk);
    rst = r; req_hi = h; req_lo = l;
    if (r) begin
      e.hi = 1'b0; e.lo = 1'b1; e.tag = "R1";
      m_prev = 1'b0; m_left = 0;
    end else begin
      if (h && !m_prev) begin
        e.hi = 1'b1; e.lo = 1'b0; e.tag = "R3"; m_left = HOLD - 1;
      end else if (m_left > 0) begin
        e.hi = 1'b1; e.lo = 1'b0; e.tag = "R3"; m_left--;
      end else if (h) begin
        e.hi = 1'b1; e.lo = 1'b0; e.tag = "R2";
      end else begin
        e.hi = 1'b0; e.lo = 1'b1; e.tag = l ? "R5" : "R4";
      end
      m_prev = h;
    end
    if (ovr != "") e.tag = ovr;
    sb.push_back(e);
  endtask

  // monitor: outputs settle after the edge, sampled 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (gnt_hi !== e.hi || gnt_lo !== e.lo) begin
          fails++;
          $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b",
                   e.tag, gnt_hi, gnt_lo, e.hi, e.lo);
        end
        checks++;
        if ($countones({gnt_hi, gnt_lo}) != 1 || $isunknown({gnt_hi, gnt_lo})) begin
          fails++;
          $display("FAIL R6: got %b%b expected one-hot", gnt_hi, gnt_lo);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1, 0, 0, "R1");
    drive(1, 0, 1, "R1");
    // R4 idle parking
    for (int i = 0; i < 3; i++) drive(0, 0, 0, "");
    // R5 low requester alone
    for (int i = 0; i < 3; i++) drive(0, 0, 1, "");
    // R3 one-cycle pulse, req_lo raised during the window
    drive(0, 1, 0, "R3");
    drive(0, 0, 1, "R3");
    drive(0, 0, 1, "R5");
    drive(0, 0, 0, "R4");
    // R2 both requesting: high side wins
    drive(0, 1, 1, "R3");
    drive(0, 1, 1, "R2");
    drive(0, 1, 1, "R2");
    // R7 long hold then release
    for (int i = 0; i < 5; i++) drive(0, 1, 0, "R7");
    drive(0, 0, 1, "R7");
    drive(0, 0, 0, "R4");
    // R8 back-to-back pulses
    drive(0, 1, 0, "R8");
    drive(0, 0, 0, "R8");
    drive(0, 1, 1, "R8");
    drive(0, 0, 1, "R8");
    drive(0, 0, 1, "R5");
    // random traffic
    for (int i = 0; i < 400; i++) drive(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "");
    // R1 reset mid-run with req_hi high, released still high: edge counts
    drive(0, 1, 0, "");
    drive(1, 1, 0, "R1");
    drive(1, 1, 1, "R1");
    drive(0, 1, 1, "R1");
    drive(0, 0, 1, "R1");
    drive(0, 0, 1, "R5");
    drive(0, 0, 0, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule